// File: doc/BRIEF.md
# Paired PWM Waveform Group

This block is one self-contained group of a pulse-width modulation generator. It owns a single period counter and drives four waveform outputs that are organised as two pairs. Software (or a neighbouring controller) programs it through a narrow synchronous write port: an address, a data word and a one-cycle strobe. Four identical copies with no shared state make a sixteen-output generator.

Two mode bits shape the waveform. The first picks edge-aligned counting (a sawtooth from zero up to one below the period) or center-aligned counting (a triangle from zero up to the period and back). The second picks paired operation, where each pair carries a signal and its exact complement driven from one duty value, or independent operation, where each of the four outputs compares against its own duty value. Period, duty and mode settings are staged in shadow registers and only copied into the working set when the counter returns to zero, so a waveform never shows a partial or glitched pulse. A one-cycle strobe marks the first cycle of every period.

Top module: `pwm_quad_group`

## Requirements
- R1: Register map on the write port (a write lands on the clock edge where `wr_en` is high): address 0 bit 0 is the run enable; address 1 bit 0 selects center-aligned counting and bit 1 selects independent outputs; address 2 holds the period; addresses 3 to 6 hold the duty values of outputs 0 to 3.
- R2: In edge-aligned mode the count runs 0, 1, ..., P-1 and wraps, so one period lasts P cycles; an output is high in every cycle whose count is below its duty value.
- R3: In center-aligned mode the count runs 0, 1, ..., P, P-1, ..., 1 and then 0 again, so one period lasts 2P cycles; an output is high in every cycle whose count is below its duty value, giving a pulse centred on the count of zero.
- R4: In paired mode output 0 follows the duty value at address 3 and output 2 follows the one at address 5; output 1 is the inverse of output 0 and output 3 the inverse of output 2 in every running cycle.
- R5: In independent mode output k is compared against its own duty value (address 3+k) and the four outputs do not influence one another.
- R6: A duty value of 0 keeps its output low for the whole period; a duty value equal to or greater than the period keeps it high for the whole period, including the peak count in center-aligned mode; a period of 0 behaves as a period of 1.
- R7: Period, duty and mode writes made while running take effect in the first cycle of the following period; the period in progress completes with the old values.
- R8: While the run enable is clear the count is held at zero and all four outputs, complements included, are low; clearing the enable takes effect in the cycle after the write.
- R9: `period_start` is high for exactly the first cycle of each period (the cycle in which the count is zero), including the first cycle after the enable is set.
- R10: After reset all registers are zero, the group is stopped, and all outputs and `period_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | 4 | Waveform outputs, pairs {1,0} and {3,2} |
| period_start | output | 1 | One-cycle marker of the first cycle of a period |

## Verification
The bound checker watches, on every cycle, the structural rules: the count stays inside the range of the active mode and steps by one in edge-aligned mode, the working registers never change in the middle of a period, paired outputs are always complementary, the stopped group stays low with the count at zero, and the period strobe is never held for two cycles except at a one-cycle period. Only the bench scenarios can show the actual waveform shapes against a model of the requirements: the duty-to-count comparison in both counting modes, the boundary duty values, the exact cycle in which staged writes take effect, and the restart after a disable.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

  localparam int NUM_PAIRS     = 2;
  localparam int NUM_CH        = 2 * NUM_PAIRS;
  localparam int REG_ENABLE    = 0;
  localparam int REG_MODE      = 1;
  localparam int REG_PERIOD    = 2;
  localparam int REG_DUTY_BASE = 3;
  localparam int NUM_REGS      = REG_DUTY_BASE + NUM_CH;
  localparam int ADDR_W        = $clog2(NUM_REGS);

  // bit 0: center-aligned counting, bit 1: independent outputs
  typedef struct packed {
    logic indep;
    logic center;
  } mode_t;

endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic                         load,
  output logic                         run,
  output mode_t                        act_mode,
  output logic [CNT_W-1:0]             act_period,
  output logic [NUM_CH-1:0][CNT_W-1:0] act_duty
);

  logic                         en_q, en_d;
  mode_t                        mode_q, mode_d;
  logic [CNT_W-1:0]             per_q, per_d;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_q, duty_d;

  // shadow next-state for control, mode and period
  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    per_d  = per_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_ENABLE)) en_d   = wr_data[0];
      if (wr_addr == ADDR_W'(REG_MODE))   mode_d = mode_t'(wr_data[1:0]);
      if (wr_addr == ADDR_W'(REG_PERIOD)) per_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      per_q  <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      per_q  <= per_d;
    end
  end

  // one shadow duty register per output
  for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(REG_DUTY_BASE + g));

    always_comb begin
      duty_d[g] = duty_q[g];
      if (sel) duty_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q[g] <= '0;
      else        duty_q[g] <= duty_d[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_duty[g] <= '0;
      else if (load) act_duty[g] <= duty_q[g];
    end
  end

  // working set, copied from the shadows only on a load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode   <= '0;
      act_period <= '0;
    end else if (load) begin
      act_mode   <= mode_q;
      act_period <= per_q;
    end
  end

  assign run = en_q;

endmodule

// File: rtl/pwm_grp_counter.sv
module pwm_grp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] eff_period,
  output logic             load,
  output logic             period_start
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             wrap;

  assign eff_period = (period == '0) ? ONE : period;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (!center) begin
      down_d = 1'b0;
      if (cnt_q >= eff_period - ONE) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (!down_q && (cnt_q < eff_period)) begin
        cnt_d  = cnt_q + ONE;
        down_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          wrap   = 1'b1;
          down_d = 1'b0;
        end else begin
          down_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt          = cnt_q;
  assign load         = !run || wrap;
  assign period_start = run && (cnt_q == '0);

endmodule

// File: rtl/pwm_grp_outputs.sv
module pwm_grp_outputs
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         run,
  input  logic                         indep,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [CNT_W-1:0]             eff_period,
  input  logic [NUM_CH-1:0][CNT_W-1:0] duty,
  output logic [NUM_CH-1:0]            pwm
);

  logic [NUM_CH-1:0] level;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign level[g] = (duty[g] >= eff_period) || (cnt < duty[g]);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hi_lvl;
    assign hi_lvl       = indep ? level[2*p+1] : !level[2*p];
    assign pwm[2*p]     = run && level[2*p];
    assign pwm[2*p+1]   = run && hi_lvl;
  end

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              period_start
);

  logic                         run;
  mode_t                        act_mode;
  logic                         act_center;
  logic                         act_indep;
  logic [CNT_W-1:0]             act_period;
  logic [NUM_CH-1:0][CNT_W-1:0] act_duty;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             eff_period;
  logic                         load;

  assign act_center = act_mode.center;
  assign act_indep  = act_mode.indep;

  pwm_grp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .load       (load),
    .run        (run),
    .act_mode   (act_mode),
    .act_period (act_period),
    .act_duty   (act_duty)
  );

  pwm_grp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .center       (act_center),
    .period       (act_period),
    .cnt          (cnt),
    .eff_period   (eff_period),
    .load         (load),
    .period_start (period_start)
  );

  pwm_grp_outputs #(.CNT_W(CNT_W)) u_out (
    .run        (run),
    .indep      (act_indep),
    .cnt        (cnt),
    .eff_period (eff_period),
    .duty       (act_duty),
    .pwm        (pwm_out)
  );

endmodule

// File: rtl/pwm_quad_group_chk.sv
module pwm_quad_group_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic             act_center,
  input logic             act_indep,
  input logic [3:0]       pwm_out,
  input logic             period_start
);

  logic [CNT_W-1:0] chk_p;
  assign chk_p = (act_period == '0) ? CNT_W'(1) : act_period;

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == 4'b0000);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  assert_pair_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act_indep) |-> (pwm_out[1] != pwm_out[0]) && (pwm_out[3] != pwm_out[2]));

  assert_edge_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act_center) |-> cnt < chk_p);

  assert_edge_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !act_center && cnt != '0) |-> cnt == $past(cnt) + CNT_W'(1));

  assert_center_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_center) |-> cnt <= chk_p);

  assert_hold_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt != '0) |->
      $stable(act_period) && $stable(act_center) && $stable(act_indep));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !(!act_center && chk_p == CNT_W'(1))) |=> !period_start);

endmodule

bind pwm_quad_group pwm_quad_group_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .cnt          (cnt),
  .act_period   (act_period),
  .act_center   (act_center),
  .act_indep    (act_indep),
  .pwm_out      (pwm_out),
  .period_start (period_start)
);

// File: tb/pwm_quad_group_test.sv
module pwm_quad_group_test;
  import pwm_grp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic [3:0]        pwm_out;
  logic              period_start;

  int n_checks = 0;
  int n_fail   = 0;

  pwm_quad_group #(.CNT_W(CNT_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int cnt_at(input bit center, input int p, input int i);
    int ep  = (p == 0) ? 1 : p;
    int pos;
    if (!center) return i % ep;
    pos = i % (2 * ep);
    return (pos <= ep) ? pos : 2 * ep - pos;
  endfunction

  function automatic logic [3:0] out_at(input bit indep, input int p, input int c,
                                        input int d0, input int d1, input int d2, input int d3);
    int ep = (p == 0) ? 1 : p;
    logic [3:0] lv;
    lv[0] = (d0 >= ep) || (c < d0);
    lv[1] = (d1 >= ep) || (c < d1);
    lv[2] = (d2 >= ep) || (c < d2);
    lv[3] = (d3 >= ep) || (c < d3);
    if (indep) return lv;
    return {~lv[2], lv[2], ~lv[0], lv[0]};
  endfunction

  // stop, program, start; returns at the first running cycle (count 0)
  task automatic cfg(input bit center, input bit indep, input int p,
                     input int d0, input int d1, input int d2, input int d3);
    wr(REG_ENABLE, 0);
    wr(REG_MODE, {indep, center});
    wr(REG_PERIOD, p);
    wr(REG_DUTY_BASE + 0, d0);
    wr(REG_DUTY_BASE + 1, d1);
    wr(REG_DUTY_BASE + 2, d2);
    wr(REG_DUTY_BASE + 3, d3);
    wr(REG_ENABLE, 1);
  endtask

  task automatic check_run(input bit center, input bit indep, input int p,
                           input int d0, input int d1, input int d2, input int d3,
                           input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int c;
      if (i > 0) @(negedge clk);
      c = cnt_at(center, p, i);
      chk({tag, " pwm_out"}, int'(pwm_out), int'(out_at(indep, p, c, d0, d1, d2, d3)));
      chk({tag, " period_start"}, int'(period_start), (c == 0) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 pwm_out after reset", int'(pwm_out), 0);
    chk("R10 period_start after reset", int'(period_start), 0);
  endtask

  task automatic t_edge_paired();
    cfg(1'b0, 1'b0, 5, 2, 0, 4, 0);
    check_run(1'b0, 1'b0, 5, 2, 0, 4, 0, 10, "R1 R2 R4 R9 edge paired");
  endtask

  task automatic t_center_paired();
    cfg(1'b1, 1'b0, 4, 2, 0, 1, 0);
    check_run(1'b1, 1'b0, 4, 2, 0, 1, 0, 16, "R3 R4 R9 center paired");
  endtask

  task automatic t_indep_edge();
    cfg(1'b0, 1'b1, 6, 0, 3, 6, 9);
    check_run(1'b0, 1'b1, 6, 0, 3, 6, 9, 12, "R5 R6 edge independent");
  endtask

  task automatic t_center_bounds();
    cfg(1'b1, 1'b1, 3, 0, 3, 1, 2);
    check_run(1'b1, 1'b1, 3, 0, 3, 1, 2, 12, "R3 R5 R6 center bounds");
  endtask

  task automatic t_period_zero();
    cfg(1'b0, 1'b0, 0, 1, 0, 0, 0);
    check_run(1'b0, 1'b0, 0, 1, 0, 0, 0, 4, "R6 period zero");
  endtask

  // staged writes during a running period (R7)
  task automatic t_double_buffer();
    cfg(1'b0, 1'b0, 8, 2, 0, 0, 0);
    for (int i = 0; i < 24; i++) begin
      int c;
      logic [3:0] eo;
      if (i > 0) begin
        @(negedge clk);
        wr_en = 1'b0;
      end
      if (i < 8) begin
        c  = cnt_at(1'b0, 8, i);
        eo = out_at(1'b0, 8, c, 2, 0, 0, 0);
      end else begin
        c  = cnt_at(1'b1, 4, i - 8);
        eo = out_at(1'b0, 4, c, 3, 0, 0, 0);
      end
      chk("R7 pwm_out staged update", int'(pwm_out), int'(eo));
      chk("R7 period_start staged update", int'(period_start), (c == 0) ? 1 : 0);
      if (i == 2) begin
        wr_en = 1'b1; wr_addr = ADDR_W'(REG_PERIOD); wr_data = CNT_W'(4);
      end else if (i == 3) begin
        wr_en = 1'b1; wr_addr = ADDR_W'(REG_DUTY_BASE); wr_data = CNT_W'(3);
      end else if (i == 4) begin
        wr_en = 1'b1; wr_addr = ADDR_W'(REG_MODE); wr_data = CNT_W'(1);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // stop in mid-waveform, stay low, then restart from count zero
  task automatic t_disable();
    wr(REG_ENABLE, 0);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8 pwm_out while stopped", int'(pwm_out), 0);
      chk("R8 period_start while stopped", int'(period_start), 0);
    end
    wr(REG_ENABLE, 1);
    check_run(1'b1, 1'b0, 4, 3, 0, 0, 0, 8, "R8 R9 restart");
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge_paired();
    t_center_paired();
    t_indep_edge();
    t_center_bounds();
    t_period_zero();
    t_double_buffer();
    t_disable();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule